// File: doc/BRIEF.md
# Multiprocessor Start and Interrupt Hub

This block sits on a register bus shared by a small group of CPUs. Every access carries the id of the CPU that makes it. With that id the block can tell a CPU who it is, report how many CPUs exist, and pop that CPU's own interrupt queue through one shared register offset. The block also holds one boot address and one boot stack value for all CPUs. It fires a one-cycle start strobe to a chosen CPU, and it keeps a run/pause level for every CPU.

Inter-processor messages carry a nonzero number. The number sits in the upper half of the written word and the target CPU index sits in the lower 16 bits. A message goes either to one CPU or to every CPU except one. Each CPU has its own FIFO queue, and a message is appended at the tail of each target's queue. A CPU's interrupt line is high while its queue holds anything. A read by the owning CPU returns the oldest entry and removes it. A write by the owning CPU throws the whole queue away.

All outputs are registered. Read data comes back with a valid strobe one cycle after the read request.

Top module: `smp_ctl`

## Requirements
- R1: A read at offset 0x00 returns the requesting CPU's id, and a read at offset 0x10 returns NCPU. Read data appears with `rsp_valid` in the cycle after the read request, and `rsp_valid` is low in every other cycle.
- R2: A write of index i (bits 15:0, i < NCPU) at offset 0x20 raises `start_pulse[i]` for exactly one cycle and sets `cpu_run[i]`. `start_addr` and `start_stack` always show the values last written at offsets 0x30 and 0x70.
- R3: A write of index i at offset 0x50 clears `cpu_run` for every CPU other than i and leaves bit i unchanged. If i >= NCPU, every bit is cleared.
- R4: A write of index i at offset 0x60 sets `cpu_run[i]` only.
- R5: A write at offset 0xA0 with a nonzero number in bits 31:16 and a target in bits 15:0 appends the number to the target's queue. The target's `ipi_irq` is then high in the next cycle.
- R6: A write at offset 0xB0 appends the number to the queue of every CPU except the one named in bits 15:0. If the named index is >= NCPU, every CPU receives it.
- R7: A read at offset 0xC0 pops and returns the oldest entry of the reading CPU's queue, in the low 16 bits, in arrival order. If the queue is empty it returns 0. `ipi_irq[c]` is low exactly when queue c is empty.
- R8: A write at offset 0xC0 empties the writing CPU's queue and clears its `ipi_ovf` bit. Other queues are not affected.
- R9: Each queue holds IPI_DEPTH (8) entries. A message sent to a full queue is dropped for that target only, and the target's `ipi_ovf` bit is set. The bit stays set until a flush.
- R10: A message with number 0 is never queued. A unicast to an index >= NCPU is dropped. A start or unpause write with an index >= NCPU has no effect.
- R11: Reads at offsets other than 0x00, 0x10 and 0xC0 return 0. Writes at offsets other than 0x20, 0x30, 0x50, 0x60, 0x70, 0xA0, 0xB0 and 0xC0 change nothing.
- R12: After reset only CPU 0 is running, every queue is empty, and `ipi_irq`, `ipi_ovf` and `start_pulse` are all zero. `start_addr` and `start_stack` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Access request this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | AW | Register offset |
| req_wdata | input | DW | Write data |
| req_cpu | input | CPU_W | Id of the requesting CPU |
| rsp_valid | output | 1 | Read data valid |
| rsp_rdata | output | DW | Read data |
| ipi_irq | output | NCPU | Per-CPU interrupt, high while its queue is non-empty |
| ipi_ovf | output | NCPU | Per-CPU sticky queue overflow flag |
| start_pulse | output | NCPU | One-cycle start strobe per CPU |
| start_addr | output | DW | Shared boot address |
| start_stack | output | DW | Shared boot stack value |
| cpu_run | output | NCPU | Per-CPU run (1) / pause (0) level |

## Verification
The assertions assume at most one access per cycle. They also assume that `req_cpu` always names an existing CPU, which makes the queue-indexed checks on `ipi_irq[req_cpu]` meaningful. The stimulus keeps to one access per cycle and uses only ids 0 to NCPU-1 for the requester. Out-of-range indices appear only in the written data, where the block must tolerate them. The sends to one queue are arranged to exceed its depth, so the drop and sticky-flag behaviour is reached before the flush clears it.

// File: rtl/smp_ctl_pkg.sv
package smp_ctl_pkg;

    localparam logic [7:0] OFS_WHOAMI  = 8'h00;
    localparam logic [7:0] OFS_COUNT   = 8'h10;
    localparam logic [7:0] OFS_START   = 8'h20;
    localparam logic [7:0] OFS_BOOTPC  = 8'h30;
    localparam logic [7:0] OFS_HOLD    = 8'h50;
    localparam logic [7:0] OFS_RELEASE = 8'h60;
    localparam logic [7:0] OFS_BOOTSP  = 8'h70;
    localparam logic [7:0] OFS_SENDONE = 8'hA0;
    localparam logic [7:0] OFS_SENDALL = 8'hB0;
    localparam logic [7:0] OFS_QUEUE   = 8'hC0;

    typedef enum logic [3:0] {
        OP_NONE,
        OP_WHOAMI,
        OP_COUNT,
        OP_START,
        OP_BOOTPC,
        OP_BOOTSP,
        OP_HOLD,
        OP_RELEASE,
        OP_SENDONE,
        OP_SENDALL,
        OP_QUEUE
    } smp_op_e;

endpackage

// File: rtl/smp_reg_dec.sv
module smp_reg_dec
    import smp_ctl_pkg::*;
#(
    parameter int unsigned AW = 8
) (
    input  logic [AW-1:0] addr,
    output smp_op_e       op
);

    always_comb begin
        op = OP_NONE;
        if (addr == AW'(OFS_WHOAMI))       op = OP_WHOAMI;
        else if (addr == AW'(OFS_COUNT))   op = OP_COUNT;
        else if (addr == AW'(OFS_START))   op = OP_START;
        else if (addr == AW'(OFS_BOOTPC))  op = OP_BOOTPC;
        else if (addr == AW'(OFS_BOOTSP))  op = OP_BOOTSP;
        else if (addr == AW'(OFS_HOLD))    op = OP_HOLD;
        else if (addr == AW'(OFS_RELEASE)) op = OP_RELEASE;
        else if (addr == AW'(OFS_SENDONE)) op = OP_SENDONE;
        else if (addr == AW'(OFS_SENDALL)) op = OP_SENDALL;
        else if (addr == AW'(OFS_QUEUE))   op = OP_QUEUE;
    end

endmodule

// File: rtl/smp_ipi_fifo.sv
module smp_ipi_fifo #(
    parameter int unsigned DEPTH = 8,
    parameter int unsigned NW    = 16,
    localparam int unsigned PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int unsigned CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push,
    input  logic          pop,
    input  logic          flush,
    input  logic [NW-1:0] din,
    output logic [NW-1:0] head,
    output logic          empty,
    output logic          ovf
);

    typedef struct packed {
        logic [DEPTH-1:0][NW-1:0] mem;
        logic [PW-1:0]            rp;
        logic [PW-1:0]            wp;
        logic [CW-1:0]            cnt;
        logic                     ovf;
    } fifo_st_t;

    fifo_st_t st_d, st_q;

    function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
        return (p == PW'(DEPTH - 1)) ? '0 : p + PW'(1);
    endfunction

    always_comb begin
        st_d = st_q;
        if (flush) begin
            st_d.rp  = '0;
            st_d.wp  = '0;
            st_d.cnt = '0;
            st_d.ovf = 1'b0;
        end else begin
            if (pop && st_q.cnt != '0) begin
                st_d.rp  = bump(st_q.rp);
                st_d.cnt = st_d.cnt - CW'(1);
            end
            if (push) begin
                if (st_d.cnt == CW'(DEPTH)) begin
                    st_d.ovf = 1'b1;
                end else begin
                    st_d.mem[st_q.wp] = din;
                    st_d.wp  = bump(st_q.wp);
                    st_d.cnt = st_d.cnt + CW'(1);
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign head  = st_q.mem[st_q.rp];
    assign empty = (st_q.cnt == '0);
    assign ovf   = st_q.ovf;

endmodule

// File: rtl/smp_ctl.sv
module smp_ctl
    import smp_ctl_pkg::*;
#(
    parameter int unsigned NCPU      = 4,
    parameter int unsigned IPI_DEPTH = 8,
    parameter int unsigned AW        = 8,
    parameter int unsigned DW        = 32,
    parameter int unsigned BOOT_CPU  = 0,
    localparam int unsigned CPU_W    = (NCPU > 1) ? $clog2(NCPU) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    input  logic             req_write,
    input  logic [AW-1:0]    req_addr,
    input  logic [DW-1:0]    req_wdata,
    input  logic [CPU_W-1:0] req_cpu,
    output logic             rsp_valid,
    output logic [DW-1:0]    rsp_rdata,
    output logic [NCPU-1:0]  ipi_irq,
    output logic [NCPU-1:0]  ipi_ovf,
    output logic [NCPU-1:0]  start_pulse,
    output logic [DW-1:0]    start_addr,
    output logic [DW-1:0]    start_stack,
    output logic [NCPU-1:0]  cpu_run
);

    localparam int unsigned NUM_W = DW - 16;

    typedef struct packed {
        logic [DW-1:0]   bootpc;
        logic [DW-1:0]   bootsp;
        logic [NCPU-1:0] run;
        logic [NCPU-1:0] pulse;
        logic            rvalid;
        logic [DW-1:0]   rdata;
    } ctl_st_t;

    ctl_st_t st_d, st_q;

    smp_op_e                    op;
    logic                       is_rd, is_wr;
    logic [15:0]                idx;
    logic [NUM_W-1:0]           num;
    logic [NCPU-1:0]            sel;
    logic [NCPU-1:0]            q_push, q_pop, q_flush, q_empty, q_ovf;
    logic [NCPU-1:0][NUM_W-1:0] q_head;

    smp_reg_dec #(.AW(AW)) u_dec (
        .addr (req_addr),
        .op   (op)
    );

    assign is_rd = req_valid && !req_write;
    assign is_wr = req_valid &&  req_write;
    assign idx   = req_wdata[15:0];
    assign num   = req_wdata[DW-1:16];

    always_comb begin
        for (int c = 0; c < NCPU; c++) begin
            sel[c]     = (idx == 16'(c));
            q_push[c]  = 1'b0;
            q_pop[c]   = is_rd && (op == OP_QUEUE) && (req_cpu == CPU_W'(c));
            q_flush[c] = is_wr && (op == OP_QUEUE) && (req_cpu == CPU_W'(c));
            if (is_wr && num != '0) begin
                if (op == OP_SENDONE) q_push[c] = sel[c];
                if (op == OP_SENDALL) q_push[c] = !sel[c];
            end
        end
    end

    generate
        for (genvar g = 0; g < NCPU; g++) begin : g_q
            smp_ipi_fifo #(.DEPTH(IPI_DEPTH), .NW(NUM_W)) u_fifo (
                .clk   (clk),
                .rst_n (rst_n),
                .push  (q_push[g]),
                .pop   (q_pop[g]),
                .flush (q_flush[g]),
                .din   (num),
                .head  (q_head[g]),
                .empty (q_empty[g]),
                .ovf   (q_ovf[g])
            );
        end
    endgenerate

    always_comb begin
        st_d        = st_q;
        st_d.pulse  = '0;
        st_d.rvalid = is_rd;
        st_d.rdata  = '0;
        if (is_rd) begin
            unique case (op)
                OP_WHOAMI: st_d.rdata = DW'(req_cpu);
                OP_COUNT:  st_d.rdata = DW'(NCPU);
                OP_QUEUE: begin
                    for (int c = 0; c < NCPU; c++) begin
                        if (req_cpu == CPU_W'(c) && !q_empty[c]) st_d.rdata = DW'(q_head[c]);
                    end
                end
                default:   st_d.rdata = '0;
            endcase
        end
        if (is_wr) begin
            unique case (op)
                OP_START: begin
                    st_d.pulse = sel;
                    st_d.run   = st_q.run | sel;
                end
                OP_BOOTPC:  st_d.bootpc = req_wdata;
                OP_BOOTSP:  st_d.bootsp = req_wdata;
                OP_HOLD:    st_d.run    = st_q.run & sel;
                OP_RELEASE: st_d.run    = st_q.run | sel;
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q     <= '0;
            st_q.run <= NCPU'(1) << BOOT_CPU;
        end else begin
            st_q <= st_d;
        end
    end

    assign rsp_valid   = st_q.rvalid;
    assign rsp_rdata   = st_q.rdata;
    assign ipi_irq     = ~q_empty;
    assign ipi_ovf     = q_ovf;
    assign start_pulse = st_q.pulse;
    assign start_addr  = st_q.bootpc;
    assign start_stack = st_q.bootsp;
    assign cpu_run     = st_q.run;

endmodule

// File: rtl/smp_ctl_chk.sv
module smp_ctl_chk
    import smp_ctl_pkg::*;
#(
    parameter int unsigned NCPU  = 4,
    parameter int unsigned AW    = 8,
    parameter int unsigned DW    = 32,
    localparam int unsigned CPU_W = (NCPU > 1) ? $clog2(NCPU) : 1
) (
    input logic             clk,
    input logic             rst_n,
    input logic             req_valid,
    input logic             req_write,
    input logic [AW-1:0]    req_addr,
    input logic [CPU_W-1:0] req_cpu,
    input logic             rsp_valid,
    input logic [DW-1:0]    rsp_rdata,
    input logic [NCPU-1:0]  ipi_irq,
    input logic [NCPU-1:0]  ipi_ovf,
    input logic [NCPU-1:0]  start_pulse,
    input logic [DW-1:0]    start_addr,
    input logic [NCPU-1:0]  cpu_run
);

    logic rd, wr, rd_known;
    assign rd = req_valid && !req_write;
    assign wr = req_valid &&  req_write;
    assign rd_known = (req_addr == AW'(OFS_WHOAMI)) || (req_addr == AW'(OFS_COUNT)) ||
                      (req_addr == AW'(OFS_QUEUE));

    p_rsp_after_read_r1: assert property (@(posedge clk) disable iff (!rst_n)
        rd |=> rsp_valid);
    p_rsp_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !rd |=> !rsp_valid);
    p_whoami_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (rd && req_addr == AW'(OFS_WHOAMI)) |=> rsp_rdata == DW'($past(req_cpu)));
    p_start_onehot_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(start_pulse));
    p_start_runs_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (start_pulse & ~cpu_run) == '0);
    p_bootpc_stable_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr && req_addr == AW'(OFS_BOOTPC)) |=> $stable(start_addr));
    p_hold_no_wake_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && req_addr == AW'(OFS_HOLD)) |=> (cpu_run & ~$past(cpu_run)) == '0);
    p_empty_pop_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (rd && req_addr == AW'(OFS_QUEUE) && !ipi_irq[req_cpu]) |=> rsp_rdata == '0);
    p_undef_read_zero_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (rd && !rd_known) |=> rsp_rdata == '0);

    generate
        for (genvar c = 0; c < NCPU; c++) begin : g_cpu
            p_flush_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
                (wr && req_addr == AW'(OFS_QUEUE) && req_cpu == CPU_W'(c))
                |=> (!ipi_irq[c] && !ipi_ovf[c]));
            p_ovf_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
                (ipi_ovf[c] && !(wr && req_addr == AW'(OFS_QUEUE) && req_cpu == CPU_W'(c)))
                |=> ipi_ovf[c]);
        end
    endgenerate

endmodule

bind smp_ctl smp_ctl_chk #(.NCPU(NCPU), .AW(AW), .DW(DW)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_valid   (req_valid),
    .req_write   (req_write),
    .req_addr    (req_addr),
    .req_cpu     (req_cpu),
    .rsp_valid   (rsp_valid),
    .rsp_rdata   (rsp_rdata),
    .ipi_irq     (ipi_irq),
    .ipi_ovf     (ipi_ovf),
    .start_pulse (start_pulse),
    .start_addr  (start_addr),
    .cpu_run     (cpu_run)
);

// File: tb/smp_ctl_tb.sv
`timescale 1ns/1ps
module smp_ctl_tb;

    localparam int NCPU  = 4;
    localparam int DEPTH = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic [7:0]  req_addr = '0;
    logic [31:0] req_wdata = '0;
    logic [1:0]  req_cpu = '0;
    logic        rsp_valid;
    logic [31:0] rsp_rdata;
    logic [3:0]  ipi_irq, ipi_ovf, start_pulse, cpu_run;
    logic [31:0] start_addr, start_stack;

    always #4 clk = ~clk;

    smp_ctl u_dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata), .req_cpu(req_cpu),
        .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .ipi_irq(ipi_irq),
        .ipi_ovf(ipi_ovf), .start_pulse(start_pulse), .start_addr(start_addr),
        .start_stack(start_stack), .cpu_run(cpu_run)
    );

    int total = 0;
    int bad   = 0;

    int          mq[NCPU][$];
    bit [3:0]    m_run = 4'b0001;
    bit [3:0]    m_ovf = '0;
    bit [3:0]    m_pulse = '0;
    int unsigned m_pc = 0, m_sp = 0, m_rd = 0;
    bit          m_rv = 0;

    task automatic check(input string tag, input string what, input longint act, input longint exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s %s act=%0h exp=%0h", tag, what, act, exp);
        end
    endtask

    task automatic push_q(input int j, input int num);
        if (mq[j].size() == DEPTH) m_ovf[j] = 1'b1;
        else mq[j].push_back(num);
    endtask

    task automatic model_step(input bit v, input bit w, input int a, input int unsigned d, input int cpu);
        int i, num;
        i = d & 32'hFFFF;
        num = d >> 16;
        m_pulse = '0;
        m_rv = 0;
        m_rd = 0;
        if (v && !w) begin
            m_rv = 1;
            if (a == 'h00) m_rd = cpu;
            else if (a == 'h10) m_rd = NCPU;
            else if (a == 'hC0 && mq[cpu].size() > 0) m_rd = mq[cpu].pop_front();
        end
        if (v && w) begin
            case (a)
                'h20: if (i < NCPU) begin m_pulse[i] = 1'b1; m_run[i] = 1'b1; end
                'h30: m_pc = d;
                'h70: m_sp = d;
                'h50: for (int j = 0; j < NCPU; j++) if (j != i) m_run[j] = 1'b0;
                'h60: if (i < NCPU) m_run[i] = 1'b1;
                'hA0: if (num != 0 && i < NCPU) push_q(i, num);
                'hB0: if (num != 0) for (int j = 0; j < NCPU; j++) if (j != i) push_q(j, num);
                'hC0: begin mq[cpu].delete(); m_ovf[cpu] = 1'b0; end
                default: ;
            endcase
        end
    endtask

    task automatic compare(input string tag);
        bit [3:0] irq;
        for (int j = 0; j < NCPU; j++) irq[j] = (mq[j].size() > 0);
        check(tag, "start_pulse", start_pulse, m_pulse);
        check(tag, "cpu_run", cpu_run, m_run);
        check(tag, "start_addr", start_addr, m_pc);
        check(tag, "start_stack", start_stack, m_sp);
        check(tag, "ipi_irq", ipi_irq, irq);
        check(tag, "ipi_ovf", ipi_ovf, m_ovf);
        check(tag, "rsp_valid", rsp_valid, m_rv);
        if (m_rv) check(tag, "rsp_rdata", rsp_rdata, m_rd);
    endtask

    task automatic acc(input bit w, input int a, input int unsigned d, input int cpu, input string tag);
        req_valid = 1'b1;
        req_write = w;
        req_addr  = 8'(a);
        req_wdata = d;
        req_cpu   = 2'(cpu);
        model_step(1'b1, w, a, d, cpu);
        @(negedge clk);
        req_valid = 1'b0;
        compare(tag);
    endtask

    task automatic idle(input string tag);
        model_step(1'b0, 1'b0, 0, 0, 0);
        @(negedge clk);
        compare(tag);
    endtask

    initial begin
        #(8 * 20000);
        bad++;
        total++;
        $display("FAIL watchdog all act=hung exp=done");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        compare("R12");
        rst_n = 1'b1;
        idle("R12");

        for (int c = 0; c < NCPU; c++) acc(0, 'h00, 0, c, "R1");
        acc(0, 'h10, 0, 2, "R1");
        idle("R1");

        acc(0, 'h30, 0, 0, "R11");
        acc(0, 'h44, 0, 1, "R11");
        acc(1, 'hF0, 32'hFFFF_FFFF, 0, "R11");
        acc(1, 'h40, 32'h0000_0002, 0, "R11");
        acc(1, 'h00, 32'h0000_0003, 0, "R11");
        idle("R11");

        acc(1, 'h30, 32'h8000_1000, 0, "R2");
        acc(1, 'h70, 32'h9000_0FF0, 0, "R2");
        acc(1, 'h20, 2, 0, "R2");
        acc(1, 'h20, 3, 0, "R2");
        idle("R2");
        acc(1, 'h20, 9, 0, "R10");
        acc(1, 'h60, 7, 0, "R10");

        acc(1, 'h50, 1, 0, "R3");
        acc(1, 'h60, 1, 0, "R4");
        acc(1, 'h60, 2, 0, "R4");
        acc(1, 'h50, 2, 0, "R3");
        acc(1, 'h60, 0, 0, "R4");
        acc(1, 'h50, 12, 0, "R3");

        acc(1, 'hA0, (5 << 16) | 1, 0, "R5");
        acc(1, 'hA0, (6 << 16) | 1, 2, "R5");
        acc(1, 'hA0, (7 << 16) | 3, 1, "R5");
        acc(0, 'hC0, 0, 1, "R7");
        acc(0, 'hC0, 0, 1, "R7");
        acc(0, 'hC0, 0, 1, "R7");
        acc(0, 'hC0, 0, 3, "R7");
        acc(0, 'hC0, 0, 0, "R7");

        acc(1, 'hB0, (9 << 16) | 0, 1, "R6");
        acc(1, 'hB0, (4 << 16) | 12, 0, "R6");
        acc(1, 'hA0, (0 << 16) | 2, 0, "R10");
        acc(1, 'hB0, (0 << 16) | 1, 0, "R10");
        acc(1, 'hA0, (3 << 16) | 9, 0, "R10");
        acc(0, 'hC0, 0, 0, "R6");
        acc(0, 'hC0, 0, 0, "R7");

        for (int k = 0; k < 8; k++) acc(1, 'hA0, ((16 + k) << 16) | 2, 0, "R9");
        acc(1, 'hB0, (40 << 16) | 0, 3, "R9");
        idle("R9");
        for (int k = 0; k < 3; k++) acc(0, 'hC0, 0, 2, "R7");
        acc(1, 'hA0, (50 << 16) | 2, 0, "R9");
        acc(1, 'hC0, 0, 2, "R8");
        acc(0, 'hC0, 0, 2, "R8");
        acc(0, 'hC0, 0, 3, "R8");
        acc(1, 'hC0, 0, 1, "R8");
        acc(0, 'hC0, 0, 3, "R7");
        idle("R8");

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule